// File: doc/BRIEF.md
# Ramp Unit Bring-Up Sequencer

This block is a bus master that brings a voltage/frequency ramp control unit from reset to a running state with no processor involvement. A pulse on the enable-start input walks a fixed table of register address/value pairs arranged in groups. For each group the sequencer first makes sure the ramp unit is ready. It then writes every register in the group and asks the unit to apply each entry in turn through a four-step request/acknowledge/clear handshake. A second start input runs the short shutdown sequence in the same way.

Every status poll has a time limit. The limit is given in microseconds and converted to clock cycles from a clock-frequency parameter. When a poll runs out of time, the whole sequence stops at once. The block then raises an error flag and reports which group and which kind of poll failed. A successful run ends with a one-cycle done pulse.

Top module: `ramp_bringup_seq`

## Requirements
- R1: After reset, busy, done and error read 0 and no bus request is made.
- R2: An enable start programs groups in this order: index 0 writes 0x30, 0x34, 0x38 (base ID 6); index 1 writes 0x10 through 0x2c in steps of 4 (base ID 14); index 2 writes 0x40 (base ID 3); indexes 3, 4 and 5 each write offset 0x50, with 0x800, 0xc00 and 0x400 in that order (ID 2). Within a group the registers are written in that listed order.
- R3: Before each group's register writes, the command register (offset 0x00) is read and written back with bit 1 set. It is then read repeatedly until bit 0 reads 0.
- R4: After a group's writes there is one apply per register, with entry ID = base ID − k for the k-th register (k from 0). Each apply has four steps. First, the config register (offset 0x60) is read and written back ORed with the ID. Second, it is read and written back ORed with 0x100. Third, it is read until bit 16+ID is 1. Fourth, 0 is written to it and it is read until bits 31:16 are all 0.
- R5: A disable start runs one group (index 6): the R3 readiness step, a write of 0x0 to offset 0x50, then one R4 apply with ID 2.
- R6: A poll that is not satisfied after CLK_MHZ×TIMEOUT_US cycles (25000 by default) ends the run. The bus makes no further writes. error goes to 1, fail_group takes the group index, and fail_phase takes 1 (readiness poll), 2 (acknowledge poll) or 3 (clear poll).
- R7: A run that completes raises done for exactly one cycle. busy drops in that same cycle and error stays 0.
- R8: error, fail_group and fail_phase hold their values until the next accepted start, which clears them to 0.
- R9: Starts are ignored while busy. If both starts arrive together, the enable sequence runs.
- R10: The master holds a request stable until ready is seen. It has at most one read outstanding, and a read completes only on a response-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Pulse: run the enable (bring-up) sequence |
| start_dis | input | 1 | Pulse: run the disable sequence |
| m_valid | output | 1 | Bus request valid |
| m_ready | input | 1 | Bus request accepted |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | ADDR_W | Byte address of the request |
| m_wdata | output | 32 | Write data |
| m_rvalid | input | 1 | Read response valid pulse |
| m_rdata | input | 32 | Read response data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Sequence stopped on a poll timeout |
| fail_group | output | 3 | Group index of the failing step |
| fail_phase | output | 2 | Failing poll kind: 1 ready, 2 acknowledge, 3 clear |

## Verification
busy rises one clock after a start is sampled, so the bench reads it at the first falling edge after the start pulse. done and error appear one clock after the response that ends the last poll, so the bench watches them at every falling edge and counts done pulses. A timeout error is due between the limit and the limit plus one poll read after the readiness poll begins, and the bench measures that window in cycles. The bus model decides each handshake at a falling edge, where the master's request already holds the value it will have at the next rising edge. It logs every write and returns each read response no sooner than the following falling edge, so a run's result is compared only after busy has dropped.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int GRP_W     = 3;
   localparam int ENT_W     = 4;
   localparam int ID_W      = 5;
   localparam int TBL_N     = 16;
   localparam int GRP_SLOTS = 1 << GRP_W;

   localparam int EN_FIRST_GRP = 0;
   localparam int EN_LAST_GRP  = 5;
   localparam int DIS_GRP      = 6;

   localparam logic [7:0] TBL_ADDR [TBL_N] = '{
      8'h30, 8'h34, 8'h38,
      8'h10, 8'h14, 8'h18, 8'h1c, 8'h20, 8'h24, 8'h28, 8'h2c,
      8'h40,
      8'h50, 8'h50, 8'h50,
      8'h50 };

   localparam logic [31:0] TBL_DATA [TBL_N] = '{
      32'h077706db, 32'h05550249, 32'h00000111,
      32'hfefebff7, 32'hfdff7fef, 32'hfbffdefb, 32'hb69b5555,
      32'h24929249, 32'h49241112, 32'h11112111, 32'h00008102,
      32'h000fc987,
      32'h00000800, 32'h00000c00, 32'h00000400,
      32'h00000000 };

   localparam int GRP_FIRST [GRP_SLOTS] = '{0, 3, 11, 12, 13, 14, 15, 15};
   localparam int GRP_LEN   [GRP_SLOTS] = '{3, 8,  1,  1,  1,  1,  1,  1};
   localparam int GRP_ID    [GRP_SLOTS] = '{6, 14, 3,  2,  2,  2,  2,  2};

   localparam logic [31:0] ROOT_SET  = 32'h0000_0002;
   localparam logic [31:0] APPLY_SET = 32'h0000_0100;
   localparam int          ACK_LSB   = 16;

   typedef enum logic [3:0] {
      S_IDLE, S_RDY_RD, S_RDY_WR, S_RDY_POLL, S_REG_WR,
      S_ID_RD, S_ID_WR, S_UPD_RD, S_UPD_WR,
      S_ACK_POLL, S_CLR_WR, S_CLR_POLL
   } seq_state_t;

   typedef enum logic [1:0] {PH_NONE, PH_READY, PH_ACK, PH_CLEAR} fail_ph_t;
endpackage

// File: rtl/rbs_table.sv
module rbs_table
   import rbs_pkg::*;
(
   input  logic [GRP_W-1:0] grp,
   input  logic [ENT_W-1:0] ent,
   output logic [7:0]       reg_addr,
   output logic [31:0]      reg_val,
   output logic [ENT_W-1:0] len,
   output logic [ID_W-1:0]  base_id
);
   logic [TBL_N-1:0] hit;
   int               idx;

   always_comb begin
      len     = ENT_W'(GRP_LEN[grp]);
      base_id = ID_W'(GRP_ID[grp]);
      idx     = GRP_FIRST[grp] + int'(ent);
   end

   for (genvar i = 0; i < TBL_N; i++) begin : g_hit
      assign hit[i] = (idx == i);
   end

   always_comb begin
      reg_addr = '0;
      reg_val  = '0;
      for (int i = 0; i < TBL_N; i++) begin
         if (hit[i]) begin
            reg_addr = TBL_ADDR[i];
            reg_val  = TBL_DATA[i];
         end
      end
   end
endmodule

// File: rtl/rbs_timer.sv
module rbs_timer #(
   parameter int LIMIT = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   initial begin
      if (LIMIT < 2) $fatal(1, "rbs_timer: LIMIT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (run && cnt != LIM) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM);

   // R6: the limit is only reached by counting poll cycles
   a_r6_expire_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(run));
   // R6: once expired the count holds until the next clear
   a_r6_expire_holds: assert property (@(posedge clk) disable iff (!rst_n)
      expired && !clr |=> expired);
endmodule

// File: rtl/ramp_bringup_seq.sv
module ramp_bringup_seq
   import rbs_pkg::*;
#(
   parameter int CLK_MHZ    = 50,
   parameter int TIMEOUT_US = 500,
   parameter int ADDR_W     = 8,
   parameter int CMD_OFS    = 'h00,
   parameter int CFG_OFS    = 'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_en,
   input  logic              start_dis,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              m_write,
   output logic [ADDR_W-1:0] m_addr,
   output logic [31:0]       m_wdata,
   input  logic              m_rvalid,
   input  logic [31:0]       m_rdata,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [GRP_W-1:0]  fail_group,
   output logic [1:0]        fail_phase
);
   localparam int LIMIT = CLK_MHZ * TIMEOUT_US;

   initial begin
      if (ADDR_W < 8)          $fatal(1, "ramp_bringup_seq: ADDR_W below 8");
      if (CMD_OFS == CFG_OFS)  $fatal(1, "ramp_bringup_seq: register offsets collide");
      if (LIMIT < 2)           $fatal(1, "ramp_bringup_seq: timeout too short");
   end

   seq_state_t       st;
   logic [GRP_W-1:0] grp, last_grp;
   logic [ENT_W-1:0] ent;
   logic             rsp_wait;
   logic [31:0]      rmw_q;

   logic [7:0]       t_addr;
   logic [31:0]      t_val;
   logic [ENT_W-1:0] t_len;
   logic [ID_W-1:0]  t_id;
   logic [ID_W-1:0]  cur_id;
   logic [4:0]       ack_pos;
   logic             ent_last, is_poll, is_rd, hs, rsp, tmr_clr, tmo;

   rbs_table u_tbl (
      .grp      (grp),
      .ent      (ent),
      .reg_addr (t_addr),
      .reg_val  (t_val),
      .len      (t_len),
      .base_id  (t_id)
   );

   assign cur_id   = t_id - ID_W'(ent);
   assign ack_pos  = 5'(ACK_LSB) + cur_id;
   assign ent_last = (ent == t_len - 1'b1);
   assign is_poll  = (st == S_RDY_POLL) || (st == S_ACK_POLL) || (st == S_CLR_POLL);
   assign is_rd    = is_poll || (st == S_RDY_RD) || (st == S_ID_RD) || (st == S_UPD_RD);
   assign busy     = (st != S_IDLE);
   assign m_valid  = busy && !rsp_wait;
   assign m_write  = !is_rd;
   assign hs       = m_valid && m_ready;
   assign rsp      = rsp_wait && m_rvalid;
   assign tmr_clr  = hs && ((st == S_RDY_WR) || (st == S_UPD_WR) || (st == S_CLR_WR));

   rbs_timer #(.LIMIT(LIMIT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .run     (is_poll),
      .expired (tmo)
   );

   always_comb begin
      m_addr  = ADDR_W'(CFG_OFS);
      m_wdata = '0;
      case (st)
         S_RDY_RD, S_RDY_POLL: m_addr = ADDR_W'(CMD_OFS);
         S_RDY_WR: begin
            m_addr  = ADDR_W'(CMD_OFS);
            m_wdata = rmw_q | ROOT_SET;
         end
         S_REG_WR: begin
            m_addr  = ADDR_W'(t_addr);
            m_wdata = t_val;
         end
         S_ID_WR:  m_wdata = rmw_q | 32'(cur_id);
         S_UPD_WR: m_wdata = rmw_q | APPLY_SET;
         default:  m_wdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         grp        <= '0;
         last_grp   <= '0;
         ent        <= '0;
         rsp_wait   <= 1'b0;
         rmw_q      <= '0;
         done       <= 1'b0;
         error      <= 1'b0;
         fail_group <= '0;
         fail_phase <= PH_NONE;
      end else begin
         done <= 1'b0;
         if (hs && is_rd) rsp_wait <= 1'b1;
         if (rsp)         rsp_wait <= 1'b0;
         case (st)
            S_IDLE: if (start_en || start_dis) begin
               grp        <= start_en ? GRP_W'(EN_FIRST_GRP) : GRP_W'(DIS_GRP);
               last_grp   <= start_en ? GRP_W'(EN_LAST_GRP)  : GRP_W'(DIS_GRP);
               ent        <= '0;
               error      <= 1'b0;
               fail_group <= '0;
               fail_phase <= PH_NONE;
               st         <= S_RDY_RD;
            end
            S_RDY_RD: if (rsp) begin
               rmw_q <= m_rdata;
               st    <= S_RDY_WR;
            end
            S_RDY_WR: if (hs) st <= S_RDY_POLL;
            S_RDY_POLL: if (rsp) begin
               if (!m_rdata[0]) begin
                  ent <= '0;
                  st  <= S_REG_WR;
               end else if (tmo) begin
                  st         <= S_IDLE;
                  error      <= 1'b1;
                  fail_group <= grp;
                  fail_phase <= PH_READY;
               end
            end
            S_REG_WR: if (hs) begin
               if (ent_last) begin
                  ent <= '0;
                  st  <= S_ID_RD;
               end else begin
                  ent <= ent + 1'b1;
               end
            end
            S_ID_RD: if (rsp) begin
               rmw_q <= m_rdata;
               st    <= S_ID_WR;
            end
            S_ID_WR: if (hs) st <= S_UPD_RD;
            S_UPD_RD: if (rsp) begin
               rmw_q <= m_rdata;
               st    <= S_UPD_WR;
            end
            S_UPD_WR: if (hs) st <= S_ACK_POLL;
            S_ACK_POLL: if (rsp) begin
               if (m_rdata[ack_pos]) begin
                  st <= S_CLR_WR;
               end else if (tmo) begin
                  st         <= S_IDLE;
                  error      <= 1'b1;
                  fail_group <= grp;
                  fail_phase <= PH_ACK;
               end
            end
            S_CLR_WR: if (hs) st <= S_CLR_POLL;
            S_CLR_POLL: if (rsp) begin
               if (m_rdata[31:16] == 16'h0) begin
                  if (!ent_last) begin
                     ent <= ent + 1'b1;
                     st  <= S_ID_RD;
                  end else if (grp == last_grp) begin
                     done <= 1'b1;
                     st   <= S_IDLE;
                  end else begin
                     grp <= grp + 1'b1;
                     ent <= '0;
                     st  <= S_RDY_RD;
                  end
               end else if (tmo) begin
                  st         <= S_IDLE;
                  error      <= 1'b1;
                  fail_group <= grp;
                  fail_phase <= PH_CLEAR;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R10: a pending request keeps its attributes until accepted
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_wdata) && $stable(m_write));
   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: completion leaves the block idle and error-free
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !error);
   // R6: an error only follows a poll response
   a_r6_err_from_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> $past(m_rvalid));
   // R6: after a failure the bus is quiet
   a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !busy && !m_valid && fail_phase != 2'd0);
   // R8: error persists until a start arrives
   a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      error && !start_en && !start_dis |=> error);
endmodule

// File: tb/tb_ramp_bringup_seq.sv
module tb_ramp_bringup_seq;
   localparam int LIMIT = 50 * 500;

   logic        clk = 1'b0;
   logic        rst_n, start_en, start_dis;
   logic        m_valid, m_ready, m_write, m_rvalid;
   logic [7:0]  m_addr;
   logic [31:0] m_wdata, m_rdata;
   logic        busy, done, error;
   logic [2:0]  fail_group;
   logic [1:0]  fail_phase;

   always #10 clk = ~clk;

   ramp_bringup_seq dut (
      .clk(clk), .rst_n(rst_n), .start_en(start_en), .start_dis(start_dis),
      .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
      .busy(busy), .done(done), .error(error),
      .fail_group(fail_group), .fail_phase(fail_phase));

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // bus model state
   logic [31:0] cmd_r, cfg_r, ack_bits, rd_val;
   int rdy_dly, ack_dly, noack_id, stuckack_id, bad_rd, rd_dly;
   bit stuck_rdy, rd_pend;
   logic [7:0]  lg_a [128];
   logic [31:0] lg_d [128];
   int lg_n;

   task automatic model_reset();
      cmd_r = 0; cfg_r = 0; ack_bits = 0; rdy_dly = 0; ack_dly = 0;
      noack_id = -1; stuckack_id = -1; stuck_rdy = 0; bad_rd = 0; lg_n = 0;
   endtask

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      lg_a[lg_n] = a; lg_d[lg_n] = d;
      if (lg_n < 127) lg_n++;
      if (a == 8'h00) begin
         cmd_r = d; rdy_dly = int'($urandom % 3);
      end else if (a == 8'h60) begin
         cfg_r = d;
         if (d[8]) ack_dly = int'($urandom % 3);
         if (d == 0 && !(stuckack_id >= 0 && ack_bits == (32'h1 << (16 + stuckack_id))))
            ack_bits = 0;
      end
   endtask

   task automatic model_read(input logic [7:0] a, output logic [31:0] v);
      v = 0;
      if (a == 8'h00) begin
         v = cmd_r;
         if (stuck_rdy) v[0] = 1'b1;
         else if (rdy_dly > 0) begin v[0] = 1'b1; rdy_dly--; end
      end else if (a == 8'h60) begin
         if (cfg_r[8] && int'(cfg_r[4:0]) != noack_id) begin
            if (ack_dly > 0) ack_dly--;
            else ack_bits = 32'h1 << (16 + cfg_r[4:0]);
         end
         v = {ack_bits[31:16], cfg_r[15:0]};
      end else bad_rd++;
   endtask

   // responder: handshake decided at falling edge, response no earlier than next one
   initial begin
      m_ready = 0; m_rvalid = 0; m_rdata = 0; rd_pend = 0; rd_dly = 0;
      forever begin
         @(negedge clk);
         m_rvalid = 0;
         if (rd_pend) begin
            if (rd_dly == 0) begin m_rvalid = 1; m_rdata = rd_val; rd_pend = 0; end
            else rd_dly--;
         end
         m_ready = ($urandom % 4) != 0;
         if (m_valid && m_ready && rst_n) begin
            if (m_write) model_write(m_addr, m_wdata);
            else begin model_read(m_addr, rd_val); rd_pend = 1; rd_dly = int'($urandom % 3); end
         end
      end
   end

   int done_cnt = 0; bit busy_at_done, err_at_done;
   always @(negedge clk) if (done) begin done_cnt++; busy_at_done = busy; err_at_done = error; end

   // expected write log from the requirements
   logic [7:0]  ta [16] = '{8'h30,8'h34,8'h38,8'h10,8'h14,8'h18,8'h1c,8'h20,
                            8'h24,8'h28,8'h2c,8'h40,8'h50,8'h50,8'h50,8'h50};
   logic [31:0] td [16] = '{32'h077706db,32'h05550249,32'h111,32'hfefebff7,32'hfdff7fef,
                            32'hfbffdefb,32'hb69b5555,32'h24929249,32'h49241112,32'h11112111,
                            32'h8102,32'hfc987,32'h800,32'hc00,32'h400,32'h0};
   int gf [7] = '{0,3,11,12,13,14,15};
   int gl [7] = '{3,8,1,1,1,1,1};
   int gi [7] = '{6,14,3,2,2,2,2};
   logic [7:0] ex_a [128]; logic [31:0] ex_d [128]; int ex_n;

   task automatic push(input logic [7:0] a, input logic [31:0] d);
      ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
   endtask

   task automatic exp_build(input bit en);
      ex_n = 0;
      for (int g = (en ? 0 : 6); g <= (en ? 5 : 6); g++) begin
         push(8'h00, 32'h2);
         for (int k = 0; k < gl[g]; k++) push(ta[gf[g]+k], td[gf[g]+k]);
         for (int k = 0; k < gl[g]; k++) begin
            push(8'h60, 32'(gi[g]-k));
            push(8'h60, 32'(gi[g]-k) | 32'h100);
            push(8'h60, 32'h0);
         end
      end
   endtask

   task automatic cmp_log(input string tag, input int n_exp);
      int bad = -1;
      chk(lg_n == n_exp, {tag, " write count"}, lg_n, n_exp);
      for (int i = 0; i < lg_n && i < ex_n; i++)
         if (bad < 0 && (lg_a[i] !== ex_a[i] || lg_d[i] !== ex_d[i])) bad = i;
      chk(bad < 0, {tag, " write sequence (addr<<32|data)"},
          (bad < 0) ? 0 : {lg_a[bad], lg_d[bad]}, (bad < 0) ? 0 : {ex_a[bad], ex_d[bad]});
   endtask

   task automatic pulse_start(input bit en, input bit dis);
      @(negedge clk);
      done_cnt = 0; start_en = en; start_dis = dis;
      @(negedge clk);
      start_en = 0; start_dis = 0;
   endtask

   task automatic wait_idle(input int max, output int cyc);
      cyc = 0;
      while (busy && cyc < max) begin @(negedge clk); cyc++; end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("[TB] FAIL R7 watchdog: busy got %0d expected 0", busy);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cyc;
      void'($urandom(32'd2024));
      model_reset();
      rst_n = 0; start_en = 0; start_dis = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0 && error == 0, "R1 idle flags", {busy, done, error}, 0);
      chk(m_valid == 0, "R1 no request", m_valid, 0);

      // R2 R3 R4 R7 R10: enable runs under random bus latency and random poll delays
      exp_build(1'b1);
      for (int r = 0; r < 4; r++) begin
         model_reset();
         pulse_start(1'b1, 1'b0);
         chk(busy == 1, "R9 busy after start", busy, 1);
         wait_idle(5000, cyc);
         @(negedge clk);
         cmp_log("R2 R3 R4 enable run", 66);
         chk(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
         chk(!busy_at_done && !err_at_done, "R7 idle at done", {busy_at_done, err_at_done}, 0);
         chk(bad_rd == 0, "R10 reads only status regs", bad_rd, 0);
         repeat ($urandom % 7) @(negedge clk);
      end

      // R5 disable run
      model_reset(); exp_build(1'b0);
      pulse_start(1'b0, 1'b1);
      wait_idle(2000, cyc); @(negedge clk);
      cmp_log("R5 disable run", 5);
      chk(done_cnt == 1, "R5 done", done_cnt, 1);

      // R9 both starts pick enable; a later start while busy is ignored
      model_reset(); exp_build(1'b1);
      pulse_start(1'b1, 1'b1);
      repeat (30) @(negedge clk);
      start_dis = 1; @(negedge clk); start_dis = 0;
      wait_idle(5000, cyc); @(negedge clk);
      cmp_log("R9 priority and ignore", 66);
      chk(done_cnt == 1, "R9 single completion", done_cnt, 1);

      // R6 readiness poll timeout
      model_reset(); stuck_rdy = 1;
      pulse_start(1'b1, 1'b0);
      wait_idle(LIMIT + 200, cyc);
      chk(cyc >= LIMIT && cyc <= LIMIT + 60, "R6 timeout window (cycles)", cyc, LIMIT);
      chk(error == 1 && fail_group == 0 && fail_phase == 1, "R6 ready fail code",
          {error, fail_group, fail_phase}, {1'b1, 3'd0, 2'd1});
      repeat (50) @(negedge clk);
      chk(lg_n == 1, "R6 no writes after abort", lg_n, 1);
      chk(error == 1 && fail_phase == 1, "R8 error held", {error, fail_phase}, {1'b1, 2'd1});

      // R8 next start clears error
      model_reset(); exp_build(1'b0);
      pulse_start(1'b0, 1'b1);
      chk(error == 0 && fail_phase == 0 && fail_group == 0, "R8 cleared by start",
          {error, fail_group, fail_phase}, 0);
      wait_idle(2000, cyc); @(negedge clk);
      cmp_log("R8 run after error", 5);

      // R6 acknowledge poll timeout in group 1
      model_reset(); exp_build(1'b1); noack_id = 14;
      pulse_start(1'b1, 1'b0);
      wait_idle(LIMIT + 2000, cyc);
      repeat (20) @(negedge clk);
      chk(error == 1 && fail_group == 1 && fail_phase == 2, "R6 ack fail code",
          {error, fail_group, fail_phase}, {1'b1, 3'd1, 2'd2});
      cmp_log("R6 writes before ack abort", 24);

      // R6 clear poll timeout in group 2
      model_reset(); exp_build(1'b1); stuckack_id = 3;
      pulse_start(1'b1, 1'b0);
      wait_idle(LIMIT + 2000, cyc);
      repeat (20) @(negedge clk);
      chk(error == 1 && fail_group == 2 && fail_phase == 3, "R6 clear fail code",
          {error, fail_group, fail_phase}, {1'b1, 3'd2, 2'd3});
      cmp_log("R6 writes before clear abort", 51);
      chk(done_cnt == 0, "R6 no done on failure", done_cnt, 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule